// File: doc/BRIEF.md
# Four-Source Interrupt Controller with Vectoring

This block gathers the interrupt events of a small microcontroller and turns them into one request to the CPU. Four events are watched: an edge on an external pin (the direction is programmable), a wrap of an 8-bit timer from its top value back to zero, any change on four upper port pins, and completion of a non-volatile memory write. Each event sets its own flag whether or not it is enabled. Three flags, their enables, the memory-write enable and a global enable share one 8-bit control register that software can read and write. The memory-write flag has its own bit, which software can read and clear.

The CPU request is the OR of every flag that has its enable set, gated by the global enable. A separate wake output leaves out the global enable, so an enabled and flagged source can bring the core out of sleep even while interrupts are masked. When the CPU accepts a request, the block strobes a return-address push and a PC load, presents the fixed vector address, and clears the global enable in the same edge. A return-from-interrupt strobe sets the global enable again.

The external pin and the port pins pass through a two-stage synchronizer. After that, an edge detector watches the pin and a last-value latch watches the port. The latch is refreshed every cycle, so a change held on the port raises the flag only once.

Top module: `irq_hub`

## Requirements
- R1: After reset the control register reads 0x00, the memory-write flag is 0, and irqReq, wakeReq, pushRet and pcLoad are 0.
- R2: Control register bit map: bit 7 global enable, bit 6 memory-write enable, bit 5 timer enable, bit 4 external-pin enable, bit 3 port-change enable, bit 2 timer flag, bit 1 external-pin flag, bit 0 port-change flag. A write with regWrEn stores all 8 bits, and regRdData returns them from the next cycle on.
- R3: When edgeRising is 1, a rising edge on extPin sets bit 1. When edgeRising is 0, a falling edge sets it. An edge in the other direction leaves bit 1 at 0. The flag reads 1 after the third rising clock edge that follows the pin change, and not after the second.
- R4: Bit 2 is set one clock edge after timerCount goes from 0xFF to 0x00. Other transitions, such as 0xFF to 0x01, leave it at 0.
- R5: A change on any portHi pin sets bit 0 after the third clock edge that follows the change. If the new value is then held, it does not set the flag again once the flag has been cleared.
- R6: A memDone pulse sets memFlag at the next edge. A memFlagClr pulse clears it at the next edge. memFlag ANDed with bit 6 is a request source.
- R7: irqReq = bit7 AND (OR over the flag/enable pairs bit0&bit3, bit1&bit4, bit2&bit5, memFlag&bit6).
- R8: wakeReq is the same OR of pairs but does not depend on bit 7.
- R9: When irqAck is high while irqReq is high, pushRet and pcLoad are 1 in that cycle, vectorAddr reads 0x0004, and bit 7 reads 0 after the edge. When irqAck is high without irqReq, pushRet and pcLoad stay 0.
- R10: A retInt pulse sets bit 7 at the next edge, unless an acceptance happens in the same cycle.
- R11: When a hardware event and a software write, or a memFlagClr, hit the same flag in the same cycle, the flag ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 1 | External interrupt pin (asynchronous) |
| edgeRising | input | 1 | 1 selects rising edge on extPin, 0 selects falling edge |
| timerCount | input | 8 | Current timer count value |
| portHi | input | 4 | Upper port pins watched for change (asynchronous) |
| memDone | input | 1 | Memory write-complete pulse |
| memFlagClr | input | 1 | Software clear of the memory-write flag |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write data |
| irqAck | input | 1 | CPU accepts the pending interrupt |
| retInt | input | 1 | Return-from-interrupt strobe |
| regRdData | output | 8 | Control register contents |
| memFlag | output | 1 | Memory write-complete flag |
| irqReq | output | 1 | Interrupt request to the CPU |
| wakeReq | output | 1 | Wake-from-sleep request |
| pushRet | output | 1 | Push the return address this cycle |
| pcLoad | output | 1 | Load the PC with vectorAddr this cycle |
| vectorAddr | output | 13 | Interrupt vector address (0x0004) |

## Verification
A software write and a hardware flag set can land on the same register bit in the same cycle. The bench provokes this by writing 0x00 on the very edge at which the timer wrap is detected, and judges it by reading back 0x04. It does the same on the memory flag by pulsing memDone and memFlagClr together and expecting the flag at 1. The acceptance strobe and a return strobe can also meet on the global enable. The checker covers that case: the clear on acceptance must win.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int REG_W        = 8;
  localparam int GIE_BIT      = 7;
  localparam int MEM_EN_BIT   = 6;
  localparam int SRC_N        = 3;  // sources whose flag and enable live in the register
  localparam int EN_BASE      = 3;  // enables at bits 3..5, flags at bits 0..2
  localparam int VEC_W        = 13;
  localparam logic [VEC_W-1:0] VEC_ADDR = 13'h0004;

  typedef struct packed {
    logic clrGie;
    logic setGie;
  } ctlStrobe_t;
endpackage

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
#(
  parameter int PORT_W      = 4,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extPin,
  input  logic              edgeRising,
  input  logic [CNT_W-1:0]  timerCount,
  input  logic [PORT_W-1:0] portHi,
  input  logic              memDone,
  input  logic              memFlagClr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  ctlStrobe_t        ctl,
  output logic [REG_W-1:0]  regRdData,
  output logic              memFlag,
  output logic              anyPend,
  output logic              gieBit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0]             extSync;
  logic [SYNC_STAGES-1:0][PORT_W-1:0] portSync;
  logic              extLast;
  logic [PORT_W-1:0] portLatch;
  logic [CNT_W-1:0]  cntLast;
  logic [REG_W-1:0]  ctrlReg, ctrlNxt;
  logic              memNxt;
  logic              extNow, extEdge, tmrWrap, chgHit;
  logic [SRC_N-1:0]  hwSet;
  logic [SRC_N-1:0]  pairHit;

  // Synchronizers and last-value registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extSync   <= '0;
      portSync  <= '0;
      extLast   <= 1'b0;
      portLatch <= '0;
      cntLast   <= '0;
    end else begin
      extSync   <= {extSync[LAST-1:0], extPin};
      portSync  <= {portSync[LAST-1:0], portHi};
      extLast   <= extSync[LAST];
      portLatch <= portSync[LAST];
      cntLast   <= timerCount;
    end
  end

  assign extNow  = extSync[LAST];
  assign extEdge = edgeRising ? (extNow & ~extLast) : (~extNow & extLast);
  assign tmrWrap = (cntLast == {CNT_W{1'b1}}) && (timerCount == '0);
  assign chgHit  = |(portSync[LAST] ^ portLatch);
  assign hwSet   = {tmrWrap, extEdge, chgHit};

  // Register update: hardware beats software
  always_comb begin
    ctrlNxt = ctrlReg;
    if (regWrEn) ctrlNxt = regWrData;
    for (int i = 0; i < SRC_N; i++) begin
      if (hwSet[i]) ctrlNxt[i] = 1'b1;
    end
    if (ctl.clrGie)      ctrlNxt[GIE_BIT] = 1'b0;
    else if (ctl.setGie) ctrlNxt[GIE_BIT] = 1'b1;
  end

  always_comb begin
    memNxt = memFlag;
    if (memDone)         memNxt = 1'b1;
    else if (memFlagClr) memNxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      memFlag <= 1'b0;
    end else begin
      ctrlReg <= ctrlNxt;
      memFlag <= memNxt;
    end
  end

  // Flag/enable pairs
  for (genvar g = 0; g < SRC_N; g++) begin : gPair
    assign pairHit[g] = ctrlReg[g] & ctrlReg[EN_BASE + g];
  end

  assign anyPend   = (|pairHit) | (memFlag & ctrlReg[MEM_EN_BIT]);
  assign gieBit    = ctrlReg[GIE_BIT];
  assign regRdData = ctrlReg;
endmodule

// File: rtl/irq_hub_ctl.sv
module irq_hub_ctl
  import irq_hub_pkg::*;
(
  input  logic             anyPend,
  input  logic             gieBit,
  input  logic             irqAck,
  input  logic             retInt,
  output ctlStrobe_t       ctl,
  output logic             irqReq,
  output logic             wakeReq,
  output logic             pushRet,
  output logic             pcLoad,
  output logic [VEC_W-1:0] vectorAddr
);
  logic accept;

  assign irqReq     = gieBit & anyPend;
  assign wakeReq    = anyPend;
  assign accept     = irqAck & irqReq;
  assign pushRet    = accept;
  assign pcLoad     = accept;
  assign vectorAddr = VEC_ADDR;
  assign ctl.clrGie = accept;
  assign ctl.setGie = retInt & ~accept;
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        extPin,
  input  logic        edgeRising,
  input  logic [7:0]  timerCount,
  input  logic [3:0]  portHi,
  input  logic        memDone,
  input  logic        memFlagClr,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  input  logic        irqAck,
  input  logic        retInt,
  output logic [7:0]  regRdData,
  output logic        memFlag,
  output logic        irqReq,
  output logic        wakeReq,
  output logic        pushRet,
  output logic        pcLoad,
  output logic [12:0] vectorAddr
);
  ctlStrobe_t ctl;
  logic       anyPend, gieBit;

  irq_hub_dp #(.PORT_W(4), .CNT_W(8), .SYNC_STAGES(2)) u_dp (
    .clk(clk), .rstN(rstN), .extPin(extPin), .edgeRising(edgeRising),
    .timerCount(timerCount), .portHi(portHi), .memDone(memDone),
    .memFlagClr(memFlagClr), .regWrEn(regWrEn), .regWrData(regWrData),
    .ctl(ctl), .regRdData(regRdData), .memFlag(memFlag),
    .anyPend(anyPend), .gieBit(gieBit)
  );

  irq_hub_ctl u_ctl (
    .anyPend(anyPend), .gieBit(gieBit), .irqAck(irqAck), .retInt(retInt),
    .ctl(ctl), .irqReq(irqReq), .wakeReq(wakeReq), .pushRet(pushRet),
    .pcLoad(pcLoad), .vectorAddr(vectorAddr)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk (
  input logic       clk,
  input logic       rstN,
  input logic       irqAck,
  input logic       retInt,
  input logic       memDone,
  input logic       memFlagClr,
  input logic [7:0] regRdData,
  input logic       memFlag,
  input logic       irqReq,
  input logic       wakeReq,
  input logic       pushRet,
  input logic       pcLoad
);
  AST_REQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> regRdData[7]); // R7
  AST_WAKE_COVERS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> wakeReq); // R8
  AST_LOAD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (pcLoad || pushRet) |-> (irqReq && irqAck)); // R9
  AST_ACCEPT_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && irqReq) |=> !regRdData[7]); // R9
  AST_RETURN_SETS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    (retInt && !(irqAck && irqReq)) |=> regRdData[7]); // R10
  AST_MEM_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    memDone |=> memFlag); // R11
  AST_MEM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (memFlagClr && !memDone) |=> !memFlag); // R6
endmodule

bind irq_hub irq_hub_chk u_chk (.*);

// File: tb/test_irq_hub.sv
module test_irq_hub;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic extPin = 0, edgeRising = 1, memDone = 0, memFlagClr = 0;
  logic regWrEn = 0, irqAck = 0, retInt = 0;
  logic [7:0] timerCount = 0, regWrData = 0, regRdData;
  logic [3:0] portHi = 0;
  logic memFlag, irqReq, wakeReq, pushRet, pcLoad;
  logic [12:0] vectorAddr;
  int nChk = 0, nFail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hub i_irq_hub (.*);

  function automatic logic pendOf(logic [7:0] r, logic m);
    return |(r[5:3] & r[2:0]) | (r[6] & m);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(logic [7:0] d);
    regWrEn = 1; regWrData = d;
    tick(1);
    regWrEn = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] expReg;
    logic expMem;
    void'($urandom(32'd5150));
    tick(3);
    // R1 reset state
    chk("R1 reg", regRdData, 8'h00);
    chk("R1 mem", memFlag, 0);
    chk("R1 req", {irqReq, wakeReq, pushRet, pcLoad}, 4'b0);
    rstN = 1;
    tick(3);

    // R3 external pin edges
    edgeRising = 1; extPin = 1;
    tick(2); chk("R3 rise early", regRdData[1], 0);
    tick(1); chk("R3 rise", regRdData[1], 1);
    wrReg(8'h00);
    extPin = 0; tick(4); chk("R3 fall ignored", regRdData[1], 0);
    edgeRising = 0; extPin = 1; tick(4); chk("R3 rise ignored", regRdData[1], 0);
    extPin = 0;
    tick(2); chk("R3 fall early", regRdData[1], 0);
    tick(1); chk("R3 fall", regRdData[1], 1);
    wrReg(8'h00);

    // R4 timer wrap
    timerCount = 8'hFE; tick(1);
    timerCount = 8'hFF; tick(1);
    timerCount = 8'h00; tick(1);
    chk("R4 wrap", regRdData[2], 1);
    wrReg(8'h00);
    timerCount = 8'hFF; tick(1);
    timerCount = 8'h01; tick(1);
    chk("R4 no wrap", regRdData[2], 0);
    timerCount = 8'h00; tick(1);
    chk("R4 01->00", regRdData[2], 0);

    // R11 hardware set beats software write
    timerCount = 8'hFF; tick(1);
    timerCount = 8'h00; wrReg(8'h00);
    chk("R11 reg", regRdData, 8'h04);
    wrReg(8'h00);

    // R5 port change
    portHi = 4'h5;
    tick(2); chk("R5 early", regRdData[0], 0);
    tick(1); chk("R5 change", regRdData[0], 1);
    wrReg(8'h00);
    tick(3); chk("R5 held", regRdData[0], 0);

    // R6 / R11 memory flag
    memDone = 1; tick(1); memDone = 0;
    chk("R6 set", memFlag, 1);
    memFlagClr = 1; tick(1); memFlagClr = 0;
    chk("R6 clear", memFlag, 0);
    memDone = 1; memFlagClr = 1; tick(1); memDone = 0; memFlagClr = 0;
    chk("R11 mem", memFlag, 1);
    wrReg(8'hC0);
    chk("R6 req", irqReq, 1);
    memFlagClr = 1; tick(1); memFlagClr = 0;
    chk("R6 req off", irqReq, 0);
    expMem = 0;

    // R2 R7 R8 random register contents
    for (int i = 0; i < 150; i++) begin
      logic [7:0] d;
      logic md, mc;
      d = 8'($urandom); md = 1'($urandom); mc = 1'($urandom);
      regWrEn = 1; regWrData = d; memDone = md; memFlagClr = mc;
      tick(1);
      regWrEn = 0; memDone = 0; memFlagClr = 0;
      expReg = d;
      expMem = md ? 1'b1 : (mc ? 1'b0 : expMem);
      chk("R2 readback", regRdData, expReg);
      chk("R6 flag", memFlag, expMem);
      chk("R7 req", irqReq, expReg[7] & pendOf(expReg, expMem));
      chk("R8 wake", wakeReq, pendOf(expReg, expMem));
    end
    memFlagClr = 1; tick(1); memFlagClr = 0;

    // R7 R8 directed
    wrReg(8'hA4); chk("R7 on", {irqReq, wakeReq}, 2'b11);
    wrReg(8'h24); chk("R8 masked", {irqReq, wakeReq}, 2'b01);
    wrReg(8'h84); chk("R7 disabled", {irqReq, wakeReq}, 2'b00);

    // R9 acceptance
    wrReg(8'hA4);
    irqAck = 1; #1;
    chk("R9 strobes", {pushRet, pcLoad}, 2'b11);
    chk("R9 vector", vectorAddr, 13'h0004);
    tick(1); irqAck = 0;
    chk("R9 gie clr", regRdData, 8'h24);
    chk("R9 req off", {irqReq, pushRet, pcLoad}, 3'b000);
    irqAck = 1; #1;
    chk("R9 no req", {pushRet, pcLoad}, 2'b00);
    tick(1); irqAck = 0;

    // R10 return
    retInt = 1; tick(1); retInt = 0;
    chk("R10 gie set", regRdData, 8'hA4);
    chk("R10 req", irqReq, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule